// File: doc/BRIEF.md
# SPI Master Transfer Phase Sequencer

This block orders the phases of one master-side SPI transaction. A one-cycle start strobe, raised when software writes the command byte, snapshots the whole transfer setup and launches the sequence. The order is fixed: an optional command byte, then an optional address of one to four bytes, then an optional token byte on reading transfers, then the write, read and dummy data phases that a 4-bit mode code selects. When the last phase finishes, the busy flag drops and a one-cycle end strobe fires.

The sequencer does not move bits itself. Each phase is cut into units and offered one at a time to a downstream shifter over a valid/ready pair. Every unit carries its phase code, the lane count, the output-enable for the data lines, its length in SCLK cycles and, for command, address and token units, the byte to send. Write units wait for transmit data to be available. Read units wait for room on the receive side. Clock division, FIFOs and the register bus are handled elsewhere.

Top module: `spi_phase_seq`

## Requirements
- R1: After reset, busy, u_valid, u_oe, xfer_end and cfg_err are 0 and u_phase is 0 (idle).
- R2: A start while idle with a legal setup sets busy on the next clock edge. Busy stays high until the last unit is accepted, and falls on the same edge where xfer_end pulses high for exactly one cycle.
- R3: Phase codes on u_phase are 1 command, 2 address, 3 token, 4 write, 5 read, 6 dummy (0 when idle). Units come out in this order: command (if cmd_en), then address (if addr_en), then token, then the data segments of the mode. The segments per mode are: 1 W; 2 R; 3 W,R; 4 R,W; 5 W,D,R; 6 R,D,W; 7 none; 8 D,W; 9 D,R.
- R4: The command phase is one unit of 8 cycles on 1 lane carrying cmd_byte. The address phase is addr_len+1 units, most significant address byte first. Address units use 1 lane when addr_fmt is 0 and the data lane count when it is 1, and each takes 8/lanes cycles.
- R5: When token_en is set and the mode contains a read segment (modes 2, 3, 4, 5, 6, 9), one token unit follows the address. Its byte is 0x69 if token_sel is 1 and 0x00 otherwise, and it uses the address-phase lane count.
- R6: A write segment is wr_cnt+1 units and a read segment is rd_cnt+1 units. Both use lanes 1, 2 or 4 for lane_sel 0, 1 or 2, and each unit lasts (unit_len+1)/lanes cycles. u_byte is 0 for these units.
- R7: A dummy segment is one unit lasting (dummy_cnt+1)*((unit_len+1)/lanes) cycles.
- R8: u_oe is 1 for command, address, token and write units, and 0 for read and dummy units and when idle.
- R9: A start with mode 0, mode 10 to 15, lane_sel 3, or mode 7 with neither cmd_en nor addr_en gives a one-cycle cfg_err pulse on the next edge. Busy stays 0 and no unit is offered.
- R10: A write unit is offered only while tx_avail is 1, and a read unit only while rx_space is 1. An offered unit that is not accepted keeps its phase, byte and length until it is accepted.
- R11: The setup inputs are captured at start. Changing them during a transfer does not change the units that are produced.
- R12: A start while busy is ignored: no extra units are offered and only one end strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command byte written, start transfer |
| cmd_en | input | 1 | Command phase enable |
| addr_en | input | 1 | Address phase enable |
| addr_fmt | input | 1 | Address uses data lane count when 1 |
| addr_len | input | 2 | Address bytes minus one |
| lane_sel | input | 2 | Data lanes: 0 single, 1 dual, 2 quad |
| mode | input | 4 | Transfer mode code |
| token_en | input | 1 | Token byte enable |
| token_sel | input | 1 | Token value 0x69 when 1, else 0x00 |
| wr_cnt | input | 9 | Write units minus one |
| rd_cnt | input | 9 | Read units minus one |
| dummy_cnt | input | 2 | Dummy units minus one |
| unit_len | input | 5 | Bits per data unit minus one |
| cmd_byte | input | 8 | Command byte |
| addr | input | 32 | Address |
| tx_avail | input | 1 | Transmit data available |
| rx_space | input | 1 | Receive side can take a unit |
| u_ready | input | 1 | Shifter accepts the offered unit |
| u_valid | output | 1 | Unit offered |
| u_phase | output | 3 | Phase code of offered unit |
| u_lanes | output | 3 | Lane count (1, 2, 4) |
| u_oe | output | 1 | Drive data lines |
| u_cycles | output | 8 | Unit length in SCLK cycles |
| u_byte | output | 8 | Byte for command, address, token units |
| busy | output | 1 | Transfer in progress |
| xfer_end | output | 1 | One-cycle end-of-transfer strobe |
| cfg_err | output | 1 | One-cycle illegal setup strobe |

## Verification
The bench goes after the phase boundaries. A sequencer that skipped the token on a read mode, or emitted one on a write-only mode, would produce a unit list of the wrong length. Address bytes sent least significant first, or lane counts not applied to the address under addr_fmt, show up as byte or cycle mismatches. Dummy lengths are checked against the scaling by unit size over lanes, and a design that ignored dummy_cnt or used the single-lane length would miscompare. Illegal modes, a reserved lane code, mode 7 without a command or address phase, a second start while busy, and a setup changed mid-transfer all target designs that start anyway, end twice or follow the live inputs.

// File: rtl/spi_phase_seq.sv
module spi_phase_seq #(
  parameter int CNT_W  = 9,
  parameter int ABYTES = 4,
  parameter int UNIT_W = 5,
  parameter int CYC_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  cmd_en,
  input  logic                  addr_en,
  input  logic                  addr_fmt,
  input  logic [1:0]            addr_len,
  input  logic [1:0]            lane_sel,
  input  logic [3:0]            mode,
  input  logic                  token_en,
  input  logic                  token_sel,
  input  logic [CNT_W-1:0]      wr_cnt,
  input  logic [CNT_W-1:0]      rd_cnt,
  input  logic [1:0]            dummy_cnt,
  input  logic [UNIT_W-1:0]     unit_len,
  input  logic [7:0]            cmd_byte,
  input  logic [8*ABYTES-1:0]   addr,
  input  logic                  tx_avail,
  input  logic                  rx_space,
  input  logic                  u_ready,
  output logic                  u_valid,
  output logic [2:0]            u_phase,
  output logic [2:0]            u_lanes,
  output logic                  u_oe,
  output logic [CYC_W-1:0]      u_cycles,
  output logic [7:0]            u_byte,
  output logic                  busy,
  output logic                  xfer_end,
  output logic                  cfg_err
);

  localparam int BW = UNIT_W + 1;
  localparam logic [2:0] PH_IDLE = 3'd0, PH_CMD = 3'd1, PH_ADDR = 3'd2, PH_TOK = 3'd3,
                         PH_WR = 3'd4, PH_RD = 3'd5, PH_DUM = 3'd6;
  localparam logic [2:0] POS_PRE = 3'd0, POS_END = 3'd7;

  logic              r_cmd_en, r_addr_en, r_fmt, r_tok_en, r_tok_sel;
  logic [1:0]        r_alen, r_lane, r_dum;
  logic [3:0]        r_mode;
  logic [CNT_W-1:0]  r_wr, r_rd, cnt, limit;
  logic [UNIT_W-1:0] r_len;
  logic [7:0]        r_cmd;
  logic [8*ABYTES-1:0] r_addr;
  logic [2:0]        pos, nxt, cur_ph;
  logic [7:0]        pres;
  logic [5:0]        segs;
  logic              tok_on, bad, last, acc;

  function automatic logic [5:0] seg_tbl(input logic [3:0] m);
    case (m)
      4'd1: seg_tbl = 6'b000001;
      4'd2: seg_tbl = 6'b000010;
      4'd3: seg_tbl = 6'b001001;
      4'd4: seg_tbl = 6'b000110;
      4'd5: seg_tbl = 6'b101101;
      4'd6: seg_tbl = 6'b011110;
      4'd8: seg_tbl = 6'b000111;
      4'd9: seg_tbl = 6'b001011;
      default: seg_tbl = 6'b000000;
    endcase
  endfunction

  function automatic logic [2:0] kind_ph(input logic [1:0] k);
    case (k)
      2'd1: kind_ph = PH_WR;
      2'd2: kind_ph = PH_RD;
      2'd3: kind_ph = PH_DUM;
      default: kind_ph = PH_IDLE;
    endcase
  endfunction

  assign segs   = seg_tbl(r_mode);
  assign tok_on = r_tok_en && (segs[1:0] == 2'd2 || segs[3:2] == 2'd2 || segs[5:4] == 2'd2);
  assign pres   = {1'b0, segs[5:4] != 2'd0, segs[3:2] != 2'd0, segs[1:0] != 2'd0,
                   tok_on, r_addr_en, r_cmd_en, 1'b0};
  assign bad    = mode == 4'd0 || mode > 4'd9 || lane_sel == 2'd3 ||
                  (mode == 4'd7 && !cmd_en && !addr_en);

  always_comb begin
    nxt = POS_END;
    for (int p = 6; p >= 1; p--)
      if (3'(p) > pos && pres[p]) nxt = 3'(p);
  end

  always_comb begin
    case (pos)
      3'd1: cur_ph = PH_CMD;
      3'd2: cur_ph = PH_ADDR;
      3'd3: cur_ph = PH_TOK;
      3'd4: cur_ph = kind_ph(segs[1:0]);
      3'd5: cur_ph = kind_ph(segs[3:2]);
      3'd6: cur_ph = kind_ph(segs[5:4]);
      default: cur_ph = PH_IDLE;
    endcase
  end

  logic [2:0]       dlanes, alanes, ashift;
  logic [BW-1:0]    ubits, per_unit;
  logic [1:0]       aidx;

  assign dlanes   = 3'd1 << r_lane;
  assign ashift   = r_fmt ? {1'b0, r_lane} : 3'd0;
  assign alanes   = 3'd1 << ashift;
  assign ubits    = BW'(r_len) + BW'(1);
  assign per_unit = ubits >> r_lane;
  assign aidx     = r_alen - cnt[1:0];

  assign u_phase = busy ? cur_ph : PH_IDLE;
  assign u_oe    = u_phase inside {PH_CMD, PH_ADDR, PH_TOK, PH_WR};
  assign u_valid = busy && pos != POS_PRE &&
                   !(cur_ph == PH_WR && !tx_avail) && !(cur_ph == PH_RD && !rx_space);
  assign acc     = u_valid && u_ready;

  always_comb begin
    u_lanes  = 3'd1;
    u_cycles = CYC_W'(8);
    u_byte   = 8'h00;
    limit    = '0;
    case (u_phase)
      PH_CMD:  u_byte = r_cmd;
      PH_ADDR: begin
        u_lanes = alanes; u_cycles = CYC_W'(4'd8 >> ashift);
        u_byte = r_addr[{aidx, 3'b000} +: 8]; limit = CNT_W'(r_alen);
      end
      PH_TOK: begin
        u_lanes = alanes; u_cycles = CYC_W'(4'd8 >> ashift);
        u_byte = r_tok_sel ? 8'h69 : 8'h00;
      end
      PH_WR:  begin u_lanes = dlanes; u_cycles = CYC_W'(per_unit); limit = r_wr; end
      PH_RD:  begin u_lanes = dlanes; u_cycles = CYC_W'(per_unit); limit = r_rd; end
      PH_DUM: begin
        u_lanes = dlanes;
        u_cycles = CYC_W'(per_unit) * CYC_W'({1'b0, r_dum} + 3'd1);
      end
      default: u_cycles = '0;
    endcase
  end

  assign last = cnt == limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; xfer_end <= 1'b0; cfg_err <= 1'b0;
      pos <= POS_PRE; cnt <= '0;
      r_cmd_en <= 1'b0; r_addr_en <= 1'b0; r_fmt <= 1'b0; r_tok_en <= 1'b0; r_tok_sel <= 1'b0;
      r_alen <= '0; r_lane <= '0; r_dum <= '0; r_mode <= '0;
      r_wr <= '0; r_rd <= '0; r_len <= '0; r_cmd <= '0; r_addr <= '0;
    end else begin
      xfer_end <= 1'b0;
      cfg_err  <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (bad) cfg_err <= 1'b1;
          else begin
            busy <= 1'b1; pos <= POS_PRE; cnt <= '0;
            r_cmd_en <= cmd_en; r_addr_en <= addr_en; r_fmt <= addr_fmt;
            r_tok_en <= token_en; r_tok_sel <= token_sel; r_alen <= addr_len;
            r_lane <= lane_sel; r_dum <= dummy_cnt; r_mode <= mode;
            r_wr <= wr_cnt; r_rd <= rd_cnt; r_len <= unit_len;
            r_cmd <= cmd_byte; r_addr <= addr;
          end
        end
      end else if (pos == POS_PRE || (acc && last)) begin
        cnt <= '0;
        if (nxt == POS_END) begin
          busy <= 1'b0; xfer_end <= 1'b1;
        end else pos <= nxt;
      end else if (acc) cnt <= cnt + 1'b1;
    end
  end

  AST_IDLE_NO_UNIT: assert property (@(posedge clk) disable iff (!rst_n) u_valid |-> busy); // R2
  AST_END_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> (!busy && $past(busy))); // R2
  AST_DUMMY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (u_phase == PH_DUM || u_phase == PH_RD) |-> !u_oe); // R8
  AST_ERR_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> !busy); // R9
  AST_WR_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (u_valid && u_phase == PH_WR) |-> tx_avail); // R10
  AST_RD_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (u_valid && u_phase == PH_RD) |-> rx_space); // R10
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (u_valid && !u_ready) |=> ($stable(u_phase) && $stable(u_byte) && $stable(u_cycles))); // R10

endmodule

// File: tb/spi_phase_seq_tb.sv
module spi_phase_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic cmd_en, addr_en, addr_fmt, token_en, token_sel;
  logic [1:0] addr_len, lane_sel, dummy_cnt;
  logic [3:0] mode;
  logic [8:0] wr_cnt, rd_cnt;
  logic [4:0] unit_len;
  logic [7:0] cmd_byte;
  logic [31:0] addr;
  logic tx_avail = 1'b0, rx_space = 1'b0, u_ready = 1'b0;
  logic u_valid, u_oe, busy, xfer_end, cfg_err;
  logic [2:0] u_phase, u_lanes;
  logic [7:0] u_cycles, u_byte;

  int vectors = 0, fails = 0, end_cnt = 0, err_cnt = 0;
  logic [22:0] exp_q[$], got_q[$];
  bit pend = 0;
  logic [22:0] pend_v;

  always #4 clk = ~clk;

  spi_phase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_en(cmd_en), .addr_en(addr_en),
    .addr_fmt(addr_fmt), .addr_len(addr_len), .lane_sel(lane_sel), .mode(mode),
    .token_en(token_en), .token_sel(token_sel), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt),
    .dummy_cnt(dummy_cnt), .unit_len(unit_len), .cmd_byte(cmd_byte), .addr(addr),
    .tx_avail(tx_avail), .rx_space(rx_space), .u_ready(u_ready), .u_valid(u_valid),
    .u_phase(u_phase), .u_lanes(u_lanes), .u_oe(u_oe), .u_cycles(u_cycles),
    .u_byte(u_byte), .busy(busy), .xfer_end(xfer_end), .cfg_err(cfg_err));

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // shifter / FIFO model and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        u_ready  = ($urandom % 4) != 0;
        tx_avail = ($urandom % 4) != 0;
        rx_space = ($urandom % 4) != 0;
      end
      #2;
      if (pend && u_valid) chk("R10 hold", {9'd0, u_phase, u_lanes, u_oe, u_cycles, u_byte}, {9'd0, pend_v});
      if (u_valid && u_phase == 3'd4) chk("R10 tx gate", tx_avail, 1);
      if (u_valid && u_phase == 3'd5) chk("R10 rx gate", rx_space, 1);
      if (u_valid && !busy) chk("R2 offer while idle", busy, 1);
      pend   = u_valid && !u_ready;
      pend_v = {u_phase, u_lanes, u_oe, u_cycles, u_byte};
      if (u_valid && u_ready) got_q.push_back({u_phase, u_lanes, u_oe, u_cycles, u_byte});
      if (xfer_end) begin end_cnt++; chk("R2 busy low at end", busy, 0); end
      if (cfg_err) err_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  function automatic logic [22:0] ent(int ph, int ln, int oe, int cyc, int b);
    return {3'(ph), 3'(ln), 1'(oe), 8'(cyc), 8'(b)};
  endfunction

  task automatic build_exp();
    int dl, al, per;
    bit rdm;
    dl  = 1 << lane_sel;
    al  = addr_fmt ? dl : 1;
    per = (int'(unit_len) + 1) / dl;
    rdm = mode inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd9};
    exp_q.delete();
    if (cmd_en) exp_q.push_back(ent(1, 1, 1, 8, cmd_byte));
    if (addr_en)
      for (int i = int'(addr_len); i >= 0; i--) exp_q.push_back(ent(2, al, 1, 8 / al, addr[8*i +: 8]));
    if (token_en && rdm) exp_q.push_back(ent(3, al, 1, 8 / al, token_sel ? 8'h69 : 8'h00));
    case (mode)
      4'd1: push_w(dl, per);
      4'd2: push_r(dl, per);
      4'd3: begin push_w(dl, per); push_r(dl, per); end
      4'd4: begin push_r(dl, per); push_w(dl, per); end
      4'd5: begin push_w(dl, per); exp_q.push_back(ent(6, dl, 0, (int'(dummy_cnt) + 1) * per, 0)); push_r(dl, per); end
      4'd6: begin push_r(dl, per); exp_q.push_back(ent(6, dl, 0, (int'(dummy_cnt) + 1) * per, 0)); push_w(dl, per); end
      4'd8: begin exp_q.push_back(ent(6, dl, 0, (int'(dummy_cnt) + 1) * per, 0)); push_w(dl, per); end
      4'd9: begin exp_q.push_back(ent(6, dl, 0, (int'(dummy_cnt) + 1) * per, 0)); push_r(dl, per); end
      default: ;
    endcase
  endtask

  task automatic push_w(int dl, int per);
    for (int i = 0; i <= int'(wr_cnt); i++) exp_q.push_back(ent(4, dl, 1, per, 0));
  endtask
  task automatic push_r(int dl, int per);
    for (int i = 0; i <= int'(rd_cnt); i++) exp_q.push_back(ent(5, dl, 0, per, 0));
  endtask

  task automatic rand_cfg();
    mode      = 4'(1 + $urandom % 9);
    cmd_en    = 1'($urandom);
    addr_en   = 1'($urandom);
    if (mode == 4'd7 && !cmd_en && !addr_en) addr_en = 1'b1;
    addr_fmt  = 1'($urandom);
    addr_len  = 2'($urandom);
    lane_sel  = 2'($urandom % 3);
    token_en  = 1'($urandom);
    token_sel = 1'($urandom);
    wr_cnt    = 9'($urandom % 6);
    rd_cnt    = 9'($urandom % 6);
    dummy_cnt = 2'($urandom);
    unit_len  = 5'(3 + $urandom % 29);
    cmd_byte  = 8'($urandom);
    addr      = $urandom;
  endtask

  task automatic run_txn(string tag, bit poke);
    int e0, r0, n;
    e0 = end_cnt; r0 = err_cnt;
    build_exp();
    got_q.delete();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    #3 chk({tag, " R2 busy after start"}, busy, 1);
    rand_cfg();                       // R11: inputs change mid-transfer
    mode = 4'd0; lane_sel = 2'($urandom);
    n = 0;
    while (end_cnt == e0 && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 3) start = 1'b1;   // R12
      if (poke && n == 4) start = 1'b0;
    end
    repeat (4) @(negedge clk);
    chk({tag, " R2 one end strobe"}, end_cnt - e0, 1);
    chk({tag, " R12 no error"}, err_cnt - r0, 0);
    chk({tag, " R3 unit count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk({tag, " R3/R4/R5/R6/R7/R8 unit"}, {9'd0, got_q[i]}, {9'd0, exp_q[i]});
  endtask

  task automatic run_bad(string tag);
    int r0, e0;
    r0 = err_cnt; e0 = end_cnt;
    got_q.delete();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    #3 chk({tag, " R9 busy stays low"}, busy, 0);
    chk({tag, " R9 error strobe"}, cfg_err, 1);
    repeat (6) @(negedge clk);
    chk({tag, " R9 single strobe"}, err_cnt - r0, 1);
    chk({tag, " R9 no units"}, got_q.size(), 0);
    chk({tag, " R9 no end"}, end_cnt - e0, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rand_cfg();
    repeat (3) @(negedge clk);
    #3;
    chk("R1 busy", busy, 0);
    chk("R1 valid", u_valid, 0);
    chk("R1 phase", u_phase, 0);
    chk("R1 oe", u_oe, 0);
    chk("R1 strobes", {xfer_end, cfg_err}, 0);
    @(negedge clk) rst_n = 1'b1;

    // directed corners
    rand_cfg(); mode = 4'd7; cmd_en = 1; addr_en = 0;             run_txn("cmd only", 0);
    rand_cfg(); mode = 4'd7; cmd_en = 0; addr_en = 1; addr_len = 3; run_txn("addr only", 0);
    rand_cfg(); mode = 4'd2; addr_en = 1; addr_fmt = 1; lane_sel = 2; token_en = 1; token_sel = 1;
    run_txn("quad addr token", 0);
    rand_cfg(); mode = 4'd1; token_en = 1; run_txn("token on write", 0);
    rand_cfg(); mode = 4'd9; lane_sel = 1; dummy_cnt = 3; unit_len = 31; run_txn("dummy dual", 0);
    rand_cfg(); mode = 4'd1; wr_cnt = 9'd511; run_txn("max write", 0);
    rand_cfg(); mode = 4'd5; run_txn("busy poke", 1);

    rand_cfg(); mode = 4'd0;  run_bad("mode0");
    rand_cfg(); mode = 4'd12; run_bad("reserved mode");
    rand_cfg(); lane_sel = 2'd3; run_bad("reserved lanes");
    rand_cfg(); mode = 4'd7; cmd_en = 0; addr_en = 0; run_bad("empty mode7");

    for (int t = 0; t < 40; t++) begin
      rand_cfg();
      run_txn("random", 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule